// File: doc/BRIEF.md
# Byte/Word Add-Subtract Status Flag Generator

This block sits beside an integer adder path and produces the result of an add or subtract together with the six arithmetic status flags: carry, auxiliary carry, zero, parity, sign and overflow. Each operation works on either the low 8 bits of the operands or the full 16 bits, chosen by a size input. Carry in is used only by the two chained operations: add-with-carry and subtract-with-borrow.

Results and flags are registered. They change only on a cycle where the valid strobe is high, and otherwise keep their last values. A separate path holds three control flags: direction, interrupt enable and single-step. Each of these flags has its own set and clear pulses. A direction value of 0 means ascending string addressing and 1 means descending.

Top module: `aluflag_unit`

## Requirements
- R1: `op_sel` uses these codes: 00 add, 01 add-with-carry, 10 subtract, 11 subtract-with-borrow. `carry_in` is added (or, for subtraction, taken away) only for codes 01 and 11. With `size_word`=1 the result is the 16-bit value. With `size_word`=0 only operand bits [7:0] are used, result bits [15:8] read 0, and operand bits [15:8] affect neither the result nor any flag.
- R2: `cf_o` is the carry out of the top bit of the selected size for an add, and the borrow out of that bit for a subtract.
- R3: `af_o` is the carry out of bit 3 for an add, and the borrow into bit 4 for a subtract. This holds for both sizes.
- R4: `zf_o` is 1 exactly when the result of the selected size is zero.
- R5: `pf_o` is 1 when result bits [7:0] contain an even number of ones. This holds for both sizes.
- R6: `sf_o` equals result bit 7 for byte operations and result bit 15 for word operations.
- R7: `of_o` is 1 when the exact signed result does not fit the selected size. For byte operations the range is -128..127; for word operations it is -32768..32767.
- R8: `result` and the six arithmetic flags show an operation's values from the clock edge that samples `in_valid`=1. When `in_valid`=0 they keep their values.
- R9: `dir_o`, `int_o` and `trap_o` change only on their own set and clear inputs. When a flag's set and clear inputs are both high in the same cycle, clear wins.
- R10: After reset, `result`, all six arithmetic flags and all three control flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation code |
| size_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| carry_in | input | 1 | Carry or borrow in |
| dir_set | input | 1 | Set the direction flag |
| dir_clr | input | 1 | Clear the direction flag |
| int_set | input | 1 | Set the interrupt-enable flag |
| int_clr | input | 1 | Clear the interrupt-enable flag |
| trap_set | input | 1 | Set the single-step flag |
| trap_clr | input | 1 | Clear the single-step flag |
| result | output | 16 | Registered result |
| cf_o | output | 1 | Carry/borrow flag |
| af_o | output | 1 | Auxiliary carry flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| dir_o | output | 1 | Direction flag (0 ascending, 1 descending) |
| int_o | output | 1 | Interrupt-enable flag |
| trap_o | output | 1 | Single-step flag |

## Verification
Every arithmetic flag is recomputed from scratch on each valid operation, so a wrong internal carry or a wrong size choice shows at the ports one edge after the faulty operation, and only on operand pairs that reach that carry. For this reason the sweeps cover every byte value of one operand against boundary values of the other, in all four operations with both carry inputs. Byte operations carry non-zero upper operand bits, so a leak from the upper byte shows up as well. A fault in the hold path or the control flags only appears after an idle cycle or a set/clear collision, so both of those are driven and checked directly.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBB = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic af;
    logic zf;
    logic pf;
    logic sf;
    logic of;
  } arith_flags_t;

  // even number of ones in a byte
  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

  // subtraction family: op code bit 1
  function automatic logic op_is_sub(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB);
  endfunction

  // chained family: op code bit 0
  function automatic logic op_uses_carry(input alu_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/aluflag_adder.sv
module aluflag_adder
  import aluflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         cin,
  input  logic         word,
  output logic [W-1:0] sum,
  output logic         c_nib_out,
  output logic         c_top_in,
  output logic         c_top_out,
  output logic         is_sub
);
  localparam int H = W / 2;

  logic [W-1:0] a_m;
  logic [W-1:0] b_m;
  logic [W-1:0] b_eff;
  logic         ci_eff;
  logic [W:0]   full;

  // carry into bit k recovered from the sum bit
  function automatic logic carry_into(input logic [W-1:0] x,
                                      input logic [W-1:0] y,
                                      input logic [W:0]   s,
                                      input int           k);
    return x[k] ^ y[k] ^ s[k];
  endfunction

  always_comb begin
    is_sub = op_is_sub(op);
    a_m    = word ? a : {{(W-H){1'b0}}, a[H-1:0]};
    b_m    = word ? b : {{(W-H){1'b0}}, b[H-1:0]};
    // subtract as a + ~b + ~borrow, masked to the active size
    b_eff  = is_sub ? (word ? ~b_m : {{(W-H){1'b0}}, ~b_m[H-1:0]}) : b_m;
    ci_eff = (op_uses_carry(op) & cin) ^ is_sub;
    full   = {1'b0, a_m} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};

    sum       = word ? full[W-1:0] : {{(W-H){1'b0}}, full[H-1:0]};
    c_nib_out = carry_into(a_m, b_eff, full, 4);
    if (word) begin
      c_top_in  = carry_into(a_m, b_eff, full, W-1);
      c_top_out = full[W];
    end else begin
      c_top_in  = carry_into(a_m, b_eff, full, H-1);
      c_top_out = full[H];
    end
  end

endmodule

// File: rtl/aluflag_eval.sv
module aluflag_eval
  import aluflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] sum,
  input  logic         word,
  input  logic         is_sub,
  input  logic         c_nib_out,
  input  logic         c_top_in,
  input  logic         c_top_out,
  output arith_flags_t flags
);
  localparam int H = W / 2;

  always_comb begin
    // inverted-operand subtract: carry out low means borrow
    flags.cf = c_top_out ^ is_sub;
    flags.af = c_nib_out ^ is_sub;
    flags.zf = (sum == '0);
    flags.pf = even_ones(sum[7:0]);
    flags.sf = word ? sum[W-1] : sum[H-1];
    flags.of = c_top_in ^ c_top_out;
  end

endmodule

// File: rtl/aluflag_hold.sv
module aluflag_hold
  import aluflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] sum_d,
  input  arith_flags_t flags_d,
  output logic [W-1:0] sum_q,
  output arith_flags_t flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      flags_q <= '0;
    end else if (load) begin
      sum_q   <= sum_d;
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/aluflag_ctrlbits.sv
module aluflag_ctrlbits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (clr_i[i]) q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/aluflag_unit.sv
module aluflag_unit
  import aluflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op_sel,
  input  logic         size_word,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  input  logic         dir_set,
  input  logic         dir_clr,
  input  logic         int_set,
  input  logic         int_clr,
  input  logic         trap_set,
  input  logic         trap_clr,
  output logic [W-1:0] result,
  output logic         cf_o,
  output logic         af_o,
  output logic         zf_o,
  output logic         pf_o,
  output logic         sf_o,
  output logic         of_o,
  output logic         dir_o,
  output logic         int_o,
  output logic         trap_o
);
  localparam int NCTL = 3;

  // internal events, named for inspection
  logic [W-1:0] sum_w;
  logic         nib_carry_w;
  logic         top_carry_in_w;
  logic         top_carry_out_w;
  logic         sub_w;
  arith_flags_t flags_w;
  arith_flags_t flags_q;
  logic [NCTL-1:0] ctl_set;
  logic [NCTL-1:0] ctl_clr;
  logic [NCTL-1:0] ctl_q;

  aluflag_adder #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .op(alu_op_e'(op_sel)), .cin(carry_in),
    .word(size_word), .sum(sum_w), .c_nib_out(nib_carry_w),
    .c_top_in(top_carry_in_w), .c_top_out(top_carry_out_w), .is_sub(sub_w)
  );

  aluflag_eval #(.W(W)) u_eval (
    .sum(sum_w), .word(size_word), .is_sub(sub_w), .c_nib_out(nib_carry_w),
    .c_top_in(top_carry_in_w), .c_top_out(top_carry_out_w), .flags(flags_w)
  );

  aluflag_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .sum_d(sum_w),
    .flags_d(flags_w), .sum_q(result), .flags_q(flags_q)
  );

  assign ctl_set = {trap_set, int_set, dir_set};
  assign ctl_clr = {trap_clr, int_clr, dir_clr};

  aluflag_ctrlbits #(.N(NCTL)) u_ctl (
    .clk(clk), .rst_n(rst_n), .set_i(ctl_set), .clr_i(ctl_clr), .q(ctl_q)
  );

  assign cf_o   = flags_q.cf;
  assign af_o   = flags_q.af;
  assign zf_o   = flags_q.zf;
  assign pf_o   = flags_q.pf;
  assign sf_o   = flags_q.sf;
  assign of_o   = flags_q.of;
  assign dir_o  = ctl_q[0];
  assign int_o  = ctl_q[1];
  assign trap_o = ctl_q[2];

endmodule

// File: rtl/aluflag_unit_chk.sv
module aluflag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         size_word,
  input logic         dir_set,
  input logic         dir_clr,
  input logic         trap_set,
  input logic         trap_clr,
  input logic [W-1:0] result,
  input logic         cf_o,
  input logic         af_o,
  input logic         zf_o,
  input logic         pf_o,
  input logic         sf_o,
  input logic         of_o,
  input logic         dir_o,
  input logic         trap_o
);
  localparam int H = W / 2;

  a_r1_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !size_word) |=> (result[W-1:H] == '0));

  a_r4_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (zf_o == (result == '0)));

  a_r5_parity_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pf_o == ~^result[7:0]));

  a_r6_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (sf_o == ($past(size_word) ? result[W-1] : result[H-1])));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable({cf_o, af_o, zf_o, pf_o, sf_o, of_o})));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dir_clr |=> !dir_o);

  a_r9_set_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_set && !dir_clr) |=> dir_o);

  a_r9_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_set && !trap_clr) |=> $stable(trap_o));

endmodule

bind aluflag_unit aluflag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_word(size_word),
  .dir_set(dir_set), .dir_clr(dir_clr), .trap_set(trap_set), .trap_clr(trap_clr),
  .result(result), .cf_o(cf_o), .af_o(af_o), .zf_o(zf_o), .pf_o(pf_o),
  .sf_o(sf_o), .of_o(of_o), .dir_o(dir_o), .trap_o(trap_o)
);

// File: tb/aluflag_unit_tb_top.sv
module aluflag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        size_word = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic        carry_in = 1'b0;
  logic dir_set = 0, dir_clr = 0, int_set = 0, int_clr = 0, trap_set = 0, trap_clr = 0;
  logic [15:0] result;
  logic cf_o, af_o, zf_o, pf_o, sf_o, of_o, dir_o, int_o, trap_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aluflag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .dir_set(dir_set), .dir_clr(dir_clr), .int_set(int_set), .int_clr(int_clr),
    .trap_set(trap_set), .trap_clr(trap_clr), .result(result),
    .cf_o(cf_o), .af_o(af_o), .zf_o(zf_o), .pf_o(pf_o), .sf_o(sf_o), .of_o(of_o),
    .dir_o(dir_o), .int_o(int_o), .trap_o(trap_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // expected values from signed/unsigned integer arithmetic
  int e_res, e_cf, e_af, e_zf, e_pf, e_sf, e_of;
  task automatic model(input int a, input int b, input int op, input int ci, input int word);
    int n, mask, c, full, sa, sb, sr, lo;
    n = word ? 16 : 8;
    mask = (1 << n) - 1;
    a = a & mask;
    b = b & mask;
    c = (op % 2 == 1) ? ci : 0;
    sa = (a >= (1 << (n - 1))) ? a - (1 << n) : a;
    sb = (b >= (1 << (n - 1))) ? b - (1 << n) : b;
    if (op >= 2) begin
      full = a - b - c;
      e_cf = (full < 0) ? 1 : 0;
      lo = (a & 15) - (b & 15) - c;
      e_af = (lo < 0) ? 1 : 0;
      sr = sa - sb - c;
    end else begin
      full = a + b + c;
      e_cf = (full > mask) ? 1 : 0;
      lo = (a & 15) + (b & 15) + c;
      e_af = (lo > 15) ? 1 : 0;
      sr = sa + sb + c;
    end
    e_res = full & mask;
    e_zf = (e_res == 0) ? 1 : 0;
    e_pf = ($countones(e_res[7:0]) % 2 == 0) ? 1 : 0;
    e_sf = (e_res >> (n - 1)) & 1;
    e_of = (sr > (1 << (n - 1)) - 1 || sr < -(1 << (n - 1))) ? 1 : 0;
  endtask

  task automatic compare_all();
    chk("R1 result", result, e_res);
    chk("R2 carry", cf_o, e_cf);
    chk("R3 aux", af_o, e_af);
    chk("R4 zero", zf_o, e_zf);
    chk("R5 parity", pf_o, e_pf);
    chk("R6 sign", sf_o, e_sf);
    chk("R7 overflow", of_o, e_of);
  endtask

  task automatic run_op(input int a, input int b, input int op, input int ci, input int word);
    @(negedge clk);
    opnd_a = a[15:0];
    opnd_b = b[15:0];
    op_sel = op[1:0];
    carry_in = ci[0];
    size_word = word[0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(a, b, op, ci, word);
    compare_all();
  endtask

  task automatic pulse_ctl(input logic [5:0] v);
    @(negedge clk);
    {dir_set, dir_clr, int_set, int_clr, trap_set, trap_clr} = v;
    @(negedge clk);
    {dir_set, dir_clr, int_set, int_clr, trap_set, trap_clr} = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int bvals[16] = '{0, 1, 2, 8'h0f, 8'h10, 8'h3f, 8'h40, 8'h7e,
                      8'h7f, 8'h80, 8'h81, 8'hbf, 8'hc0, 8'hf0, 8'hfe, 8'hff};
    int wvals[8]  = '{0, 1, 16'h000f, 16'h00ff, 16'h7fff, 16'h8000, 16'hfffe, 16'hffff};
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 result", result, 0);
    chk("R10 arith flags", {cf_o, af_o, zf_o, pf_o, sf_o, of_o}, 0);
    chk("R10 ctl flags", {dir_o, int_o, trap_o}, 0);
    rst_n = 1'b1;

    // R1-R7 byte sweep, upper operand bits deliberately non-zero
    for (int op = 0; op < 4; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 256; a++)
          for (int k = 0; k < 16; k++)
            run_op(((a * 37 + k) & 16'hff) << 8 | a, (k * 16'h1300) | bvals[k], op, ci, 0);

    // R1-R7 word corners
    for (int op = 0; op < 4; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run_op(wvals[i], wvals[j], op, ci, 1);

    // R1-R7 word pseudo-random
    lf = 16'hace1;
    for (int i = 0; i < 3000; i++) begin
      int ra;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ra = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_op(ra, lf, i % 4, (i / 4) % 2, 1);
    end

    // R8: idle cycles with new operands keep last values
    run_op(16'h7fff, 16'h0001, 0, 0, 1);
    @(negedge clk);
    opnd_a = 16'h0000;
    opnd_b = 16'h0000;
    op_sel = 2'b10;
    repeat (3) @(negedge clk);
    compare_all();

    // R9: control flags
    pulse_ctl(6'b100000);
    chk("R9 dir set", {dir_o, int_o, trap_o}, 3'b100);
    pulse_ctl(6'b001010);
    chk("R9 int+trap set", {dir_o, int_o, trap_o}, 3'b111);
    pulse_ctl(6'b110000);
    chk("R9 dir clear wins", {dir_o, int_o, trap_o}, 3'b011);
    run_op(16'h1234, 16'h4321, 1, 1, 1);
    chk("R9 ops leave ctl", {dir_o, int_o, trap_o}, 3'b011);
    pulse_ctl(6'b000111);
    chk("R9 int/trap clear", {dir_o, int_o, trap_o}, 3'b000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule